// File: doc/BRIEF.md
# Warp-Threshold Cache Bypass Router

This block sits in front of a GPU-style data cache and steers each incoming read request either into the cache lookup queue or straight into the request queue of the next memory level. The decision is made per warp. The warp index is taken from the program-visible thread index carried by the request, by dropping its five low bits (32 threads per warp). That warp index is compared with a small threshold register. The threshold is written once when a kernel is launched.

Warps numbered below the threshold use the cache. Every other warp skips it. So for a fixed threshold, a given warp is always cached or always bypassed for its whole lifetime. This limits how many warps compete for cache space, and it never splits a warp's coalesced accesses between the two paths.

A threshold of zero sends all traffic around the cache. A threshold equal to the warp count of the kernel sends all of it through the cache. Each output uses a valid/ready handshake. A single registered holding slot keeps requests in order and passes each one to exactly one destination. One counter per output counts completed transfers.

Top module: `warp_steer_router`

## Requirements
- R1: After synchronous reset, both output valids are low, both counters are zero, the input is ready, and the threshold is zero, so the first requests bypass the cache.
- R2: The warp index of a request is bits [9:5] of its 10-bit thread index; bits [4:0] have no effect on where the request goes.
- R3: A request whose warp index is strictly less than the threshold appears on the cache-queue output (cq_*) with its thread index and address unchanged.
- R4: A request whose warp index is greater than or equal to the threshold appears on the lower-level output (lq_*) with its thread index and address unchanged.
- R5: With threshold 0 every warp bypasses. With threshold 31, warps 0 to 30 are cached and warp 31 bypasses.
- R6: The route is fixed when a request is accepted, using the threshold held before any write in that same cycle. A threshold write made while a request is held does not redirect that request.
- R7: A request accepted at a clock edge is presented on its output from that edge on. It stays valid and unchanged until that output's ready is high at an edge. The input is ready exactly when the slot is empty or is being emptied in that cycle.
- R8: Each accepted request appears exactly once, on one output only, and requests keep their arrival order on each output.
- R9: cached_count and bypass_count each increase by one at every edge where their output completes a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Threshold write strobe (issued at kernel launch) |
| cfg_thresh | input | 5 | New threshold value |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Router can accept a request |
| req_tid | input | 10 | Program-visible thread index of the request |
| req_addr | input | 32 | Read address |
| cq_valid | output | 1 | Request for the cache lookup queue |
| cq_ready | input | 1 | Cache queue accepts |
| cq_tid | output | 10 | Thread index toward the cache queue |
| cq_addr | output | 32 | Address toward the cache queue |
| lq_valid | output | 1 | Request for the lower-level queue |
| lq_ready | input | 1 | Lower-level queue accepts |
| lq_tid | output | 10 | Thread index toward the lower level |
| lq_addr | output | 32 | Address toward the lower level |
| cached_count | output | 16 | Completed cache-queue transfers |
| bypass_count | output | 16 | Completed lower-level transfers |

## Verification
A request handed over at edge k shows on its output valid right after edge k. It leaves the output at the first later edge where that output's ready is high, and the matching counter moves at that same edge. A threshold write at edge k steers only requests accepted after edge k.

The bench changes inputs on the falling edge and samples every handshake half a low phase later. At each sample it sees exactly the values the next rising edge will use. Expected routes are recorded at the moment of acceptance, from a bench-side copy of the threshold that is updated only after the write edge. Counters are compared after the outputs have drained.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  // Thread index bits dropped to form the warp index (32 threads per warp).
  localparam int WARP_SHIFT = 5;

  typedef enum logic {
    ROUTE_LOWER = 1'b0,
    ROUTE_CACHE = 1'b1
  } route_e;
endpackage

// File: rtl/wsr_warp_classify.sv
module wsr_warp_classify
  import wsr_pkg::*;
#(
  parameter int TID_W = 10,
  parameter int THR_W = 5
) (
  input  logic [TID_W-1:0] tid,
  input  logic [THR_W-1:0] thr,
  output route_e           route
);
  localparam int WARP_W = TID_W - WARP_SHIFT;
  localparam int CMP_W  = (WARP_W > THR_W) ? WARP_W : THR_W;

  logic [WARP_W-1:0] warp_idx;
  logic [CMP_W-1:0]  warp_ext;
  logic [CMP_W-1:0]  thr_ext;

  always_comb begin
    warp_idx = tid[TID_W-1:WARP_SHIFT];
    warp_ext = CMP_W'(warp_idx);
    thr_ext  = CMP_W'(thr);
    route    = (warp_ext < thr_ext) ? ROUTE_CACHE : ROUTE_LOWER;
  end
endmodule

// File: rtl/wsr_hold_stage.sv
module wsr_hold_stage
  import wsr_pkg::*;
#(
  parameter int DATA_W = 42
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  route_e            in_route,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output route_e            out_route,
  input  logic              out_take
);
  logic              slot_v;
  logic [DATA_W-1:0] slot_d;
  route_e            slot_r;

  assign in_ready  = !slot_v || out_take;
  assign out_valid = slot_v;
  assign out_data  = slot_d;
  assign out_route = slot_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v <= 1'b0;
      slot_d <= '0;
      slot_r <= ROUTE_LOWER;
    end else if (in_ready) begin
      slot_v <= in_valid;
      if (in_valid) begin
        slot_d <= in_data;
        slot_r <= in_route;
      end
    end
  end
endmodule

// File: rtl/wsr_fire_counter.sv
module wsr_fire_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/warp_steer_router.sv
module warp_steer_router
  import wsr_pkg::*;
#(
  parameter int TID_W  = 10,
  parameter int THR_W  = 5,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [THR_W-1:0]  cfg_thresh,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              cq_valid,
  input  logic              cq_ready,
  output logic [TID_W-1:0]  cq_tid,
  output logic [ADDR_W-1:0] cq_addr,
  output logic              lq_valid,
  input  logic              lq_ready,
  output logic [TID_W-1:0]  lq_tid,
  output logic [ADDR_W-1:0] lq_addr,
  output logic [CNT_W-1:0]  cached_count,
  output logic [CNT_W-1:0]  bypass_count
);
  localparam int DATA_W = TID_W + ADDR_W;
  localparam int N_DEST = 2;

  logic [THR_W-1:0]  thr_q;
  route_e            in_route;
  logic              slot_v;
  logic [DATA_W-1:0] slot_d;
  route_e            slot_r;
  logic              take;
  logic [N_DEST-1:0] dest_fire;
  logic [CNT_W-1:0]  dest_cnt [N_DEST];

  // Launch-time threshold; a write lands at the edge, after that cycle's accept decision.
  always_ff @(posedge clk) begin
    if (rst)         thr_q <= '0;
    else if (cfg_we) thr_q <= cfg_thresh;
  end

  wsr_warp_classify #(.TID_W(TID_W), .THR_W(THR_W)) classify_i (
    .tid   (req_tid),
    .thr   (thr_q),
    .route (in_route)
  );

  assign dest_fire[0] = slot_v && (slot_r == ROUTE_LOWER) && lq_ready;
  assign dest_fire[1] = slot_v && (slot_r == ROUTE_CACHE) && cq_ready;
  assign take         = |dest_fire;

  wsr_hold_stage #(.DATA_W(DATA_W)) hold_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   ({req_tid, req_addr}),
    .in_route  (in_route),
    .out_valid (slot_v),
    .out_data  (slot_d),
    .out_route (slot_r),
    .out_take  (take)
  );

  assign cq_valid = slot_v && (slot_r == ROUTE_CACHE);
  assign lq_valid = slot_v && (slot_r == ROUTE_LOWER);
  assign {cq_tid, cq_addr} = slot_d;
  assign {lq_tid, lq_addr} = slot_d;

  for (genvar g = 0; g < N_DEST; g++) begin : g_cnt
    wsr_fire_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst   (rst),
      .inc   (dest_fire[g]),
      .count (dest_cnt[g])
    );
  end

  assign bypass_count = dest_cnt[0];
  assign cached_count = dest_cnt[1];
endmodule

// File: rtl/wsr_checker.sv
module wsr_checker #(
  parameter int TID_W = 10,
  parameter int THR_W = 5,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [THR_W-1:0] cfg_thresh,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TID_W-1:0] req_tid,
  input logic             cq_valid,
  input logic             cq_ready,
  input logic [TID_W-1:0] cq_tid,
  input logic             lq_valid,
  input logic             lq_ready,
  input logic [TID_W-1:0] lq_tid,
  input logic [CNT_W-1:0] cached_count,
  input logic [CNT_W-1:0] bypass_count
);
  localparam int SHIFT = 5;

  logic [THR_W-1:0] shadow_thr;
  logic             want_cache;

  // Independent model: threshold seen from the config port, route latched at accept.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_thr <= '0;
      want_cache <= 1'b0;
    end else begin
      if (req_valid && req_ready)
        want_cache <= (32'(req_tid >> SHIFT) < 32'(shadow_thr));
      if (cfg_we) shadow_thr <= cfg_thresh;
    end
  end

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
    !(cq_valid && lq_valid)); // R8
  AST_CACHE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    cq_valid |-> want_cache); // R3
  AST_LOWER_ROUTE: assert property (@(posedge clk) disable iff (rst)
    lq_valid |-> !want_cache); // R4
  AST_CQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && !cq_ready) |=> (cq_valid && $stable(cq_tid))); // R7
  AST_LQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lq_valid && !lq_ready) |=> (lq_valid && $stable(lq_tid))); // R7
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
    (!cq_valid && !lq_valid) |-> req_ready); // R7
  AST_CACHED_CNT: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && cq_ready) |=> (cached_count == CNT_W'($past(cached_count) + 1'b1))); // R9
  AST_BYPASS_CNT: assert property (@(posedge clk) disable iff (rst)
    (lq_valid && lq_ready) |=> (bypass_count == CNT_W'($past(bypass_count) + 1'b1))); // R9
endmodule

bind warp_steer_router wsr_checker #(.TID_W(TID_W), .THR_W(THR_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .cfg_thresh   (cfg_thresh),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_tid      (req_tid),
  .cq_valid     (cq_valid),
  .cq_ready     (cq_ready),
  .cq_tid       (cq_tid),
  .lq_valid     (lq_valid),
  .lq_ready     (lq_ready),
  .lq_tid       (lq_tid),
  .cached_count (cached_count),
  .bypass_count (bypass_count)
);

// File: tb/warp_steer_router_tb_top.sv
`timescale 1ns/1ps
module warp_steer_router_tb_top;
  localparam int TID_W = 10, THR_W = 5, ADDR_W = 32, CNT_W = 16, QD = 2048;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [THR_W-1:0] cfg_thresh = '0;
  logic req_valid = 1'b0, req_ready;
  logic [TID_W-1:0] req_tid = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic cq_valid, cq_ready = 1'b1, lq_valid, lq_ready = 1'b1;
  logic [TID_W-1:0] cq_tid, lq_tid;
  logic [ADDR_W-1:0] cq_addr, lq_addr;
  logic [CNT_W-1:0] cached_count, bypass_count;

  int n_tests = 0, n_fail = 0;
  int bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [THR_W-1:0] thr_model = '0;

  logic [TID_W-1:0]  exp_c_tid [QD];
  logic [ADDR_W-1:0] exp_c_addr[QD];
  logic [TID_W-1:0]  exp_l_tid [QD];
  logic [ADDR_W-1:0] exp_l_addr[QD];
  int wr_c = 0, rd_c = 0, wr_l = 0, rd_l = 0;

  always #10 clk = ~clk;

  warp_steer_router #(.TID_W(TID_W), .THR_W(THR_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_thresh(cfg_thresh),
    .req_valid(req_valid), .req_ready(req_ready), .req_tid(req_tid), .req_addr(req_addr),
    .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_tid(cq_tid), .cq_addr(cq_addr),
    .lq_valid(lq_valid), .lq_ready(lq_ready), .lq_tid(lq_tid), .lq_addr(lq_addr),
    .cached_count(cached_count), .bypass_count(bypass_count));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Ready patterns for both outputs, changed on the falling edge.
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (bp_mode)
      0: begin cq_ready = 1'b1; lq_ready = 1'b1; end
      1: begin cq_ready = lfsr[0] | lfsr[3]; lq_ready = lfsr[1] | lfsr[6]; end
      default: begin cq_ready = 1'b0; lq_ready = 1'b0; end
    endcase
  end

  // Output monitor: order, payload, single destination, hold while stalled (R3 R4 R7 R8).
  initial begin
    logic pc_stall, pl_stall;
    logic [ADDR_W-1:0] pc_addr, pl_addr;
    pc_stall = 1'b0; pl_stall = 1'b0; pc_addr = '0; pl_addr = '0;
    forever begin
      @(negedge clk); #5;
      if (!rst) begin
        if (cq_valid && lq_valid) check(1'b0, "R8 both outputs valid", 1, 0);
        if (pc_stall) check(cq_valid && cq_addr == pc_addr, "R7 cq held", cq_addr, pc_addr);
        if (pl_stall) check(lq_valid && lq_addr == pl_addr, "R7 lq held", lq_addr, pl_addr);
        pc_stall = cq_valid && !cq_ready; pc_addr = cq_addr;
        pl_stall = lq_valid && !lq_ready; pl_addr = lq_addr;
        if (cq_valid && cq_ready) begin
          if (rd_c >= wr_c) check(1'b0, "R3 unexpected cached request", cq_addr, -1);
          else begin
            check(cq_tid == exp_c_tid[rd_c] && cq_addr == exp_c_addr[rd_c],
                  "R3 cached order/payload", cq_addr, exp_c_addr[rd_c]);
            rd_c++;
          end
        end
        if (lq_valid && lq_ready) begin
          if (rd_l >= wr_l) check(1'b0, "R4 unexpected bypassed request", lq_addr, -1);
          else begin
            check(lq_tid == exp_l_tid[rd_l] && lq_addr == exp_l_addr[rd_l],
                  "R4 bypassed order/payload", lq_addr, exp_l_addr[rd_l]);
            rd_l++;
          end
        end
      end
    end
  end

  // One cycle of input drive; returns whether the request was accepted at the coming edge.
  task automatic step(input bit v, input logic [TID_W-1:0] tid, input logic [ADDR_W-1:0] addr,
                      input bit we, input logic [THR_W-1:0] thr, output bit acc);
    @(negedge clk);
    req_valid = v; req_tid = tid; req_addr = addr; cfg_we = we; cfg_thresh = thr;
    #5;
    acc = v && req_ready;
    if (acc) begin
      // R2 R6: route from warp bits [9:5] against the threshold held before this edge
      if (tid[9:5] < thr_model) begin
        exp_c_tid[wr_c] = tid; exp_c_addr[wr_c] = addr; wr_c++;
      end else begin
        exp_l_tid[wr_l] = tid; exp_l_addr[wr_l] = addr; wr_l++;
      end
    end
    @(posedge clk);
    if (we) thr_model = thr;
  endtask

  task automatic send(input logic [TID_W-1:0] tid, input logic [ADDR_W-1:0] addr,
                      input bit we, input logic [THR_W-1:0] thr);
    bit acc, w;
    w = we;
    do begin
      step(1'b1, tid, addr, w, thr, acc);
      w = 1'b0;
    end while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, '0, acc);
  endtask

  task automatic drain_and_count(input string tag);
    bp_mode = 0;
    idle(6);
    check(rd_c == wr_c && rd_l == wr_l, {tag, " R8 every request delivered once"}, rd_c + rd_l, wr_c + wr_l);
    check(cached_count == CNT_W'(wr_c), {tag, " R9 cached_count"}, cached_count, wr_c);
    check(bypass_count == CNT_W'(wr_l), {tag, " R9 bypass_count"}, bypass_count, wr_l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", rd_c + rd_l, wr_c + wr_l);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int pre_c, pre_l;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #5;
    // R1 reset state
    check(!cq_valid && !lq_valid, "R1 outputs idle after reset", cq_valid | lq_valid, 0);
    check(cached_count == 0 && bypass_count == 0, "R1 counters zero", cached_count + bypass_count, 0);
    check(req_ready == 1'b1, "R1 input ready", req_ready, 1);
    // R1 R5: threshold 0 after reset, so warp 0 bypasses
    send(10'h000, 32'hF000_0000, 1'b0, '0);
    drain_and_count("R1");
    check(wr_l == 1 && wr_c == 0, "R1 first request bypasses", wr_l, 1);

    // Sweep every threshold against every warp, low tid bits varied (R2 R3 R4 R5)
    for (int t = 0; t < 32; t++) begin
      bp_mode = t % 2;
      pre_c = wr_c; pre_l = wr_l;
      send(10'h3FF, 32'hE000_0000 + 32'(t), 1'b1, 5'(t)); // warp 31, routed with the old threshold
      for (int k = 0; k < 32; k++) begin
        logic [4:0] w, lo;
        w = 5'((k * 7 + t) % 32);
        lo = 5'((k * 3 + t) % 32);
        send({w, lo}, {16'(t), 16'(k)}, 1'b0, '0);
      end
      drain_and_count("sweep");
      if (t == 0)  check(wr_c - pre_c == 0, "R5 threshold 0 caches nothing", wr_c - pre_c, 0);
      if (t == 31) check(wr_c - pre_c == 31, "R5 threshold 31 caches warps 0..30", wr_c - pre_c, 31);
      check(wr_c - pre_c == ((t == 0) ? 0 : t + (thr_model == 5'(t) ? 0 : 0)) ||
            wr_c - pre_c == t, "R3 cached share equals threshold", wr_c - pre_c, t);
    end

    // R6: write in the accept cycle uses the old threshold (31), later write while held ignored
    bp_mode = 2;
    idle(1);
    pre_c = wr_c; pre_l = wr_l;
    send(10'h065, 32'hD000_0001, 1'b1, 5'd2);  // warp 3, 3 < 31 -> cache
    begin
      bit acc;
      step(1'b0, '0, '0, 1'b1, 5'd0, acc);   // threshold 0 while the request is held
    end
    #5;
    check(cq_valid && !lq_valid, "R6 held request stays on cache output", cq_valid, 1);
    bp_mode = 0;
    idle(3);
    send(10'h066, 32'hD000_0002, 1'b0, '0);   // warp 3 now bypasses (threshold 0)
    drain_and_count("R6");
    check(wr_c - pre_c == 1 && wr_l - pre_l == 1, "R6 old then new threshold", wr_c - pre_c, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule